// File: doc/BRIEF.md
# Rotating-Frame Three-Phase Current Regulator

This block is the inner current loop of a three-phase grid-tied inverter. At each control sample it takes three phase current references, three measured phase currents and a phase word for the grid angle. It forms the per-phase error, rotates that error into a frame that turns with the grid, and regulates the direct and quadrature components with two proportional-integral stages. The two stage outputs are rotated back into three phase modulation indexes that feed a PWM generator.

At the fundamental frequency the currents appear as constant values in the rotating frame. The integrators can therefore remove the steady-state error. The integral gain is twice the value a per-phase stationary regulator would use. Sine and cosine come from a 17-entry quarter-wave table that is folded by symmetry.

The block is fully pipelined. A new sample may enter on any clock. The sample rate, for example 10 kHz, is set by how often the surrounding system asserts the sample strobe.

Top module: `dqc_current_reg`

## Requirements
- R1: While reset is held and after its release, `modValid` is low and all three modulation outputs are zero until the first sample arrives.
- R2: A sample taken on a clock edge where `sampleValid` is high raises `modValid` for exactly one cycle after the fourth rising edge, counting the capture edge. The modulation outputs change only on that edge.
- R3: Each measured current is scaled by 1/25 (multiplied by 2621/65536 and rounded to nearest) before it is subtracted from its reference. When every measured current is 25 times its reference, all three outputs are exactly 0.
- R4: The phase error is mapped to αβ with a sqrt(2/3) scale, α = k(a − b/2 − c/2) and β = k·(√3/2)(b − c). It is then rotated as d = cosθ·α + sinθ·β and q = cosθ·β − sinθ·α. Every output lies within 40 counts of exact arithmetic.
- R5: Each axis produces u = (KP/256)·e + I. After each sample, I grows by (2·KI/256)·e, which is twice the per-phase integral gain KI. The integrators start from zero after reset.
- R6: `theta` is a 6-bit unsigned word. Value n stands for the angle 2π·n/64, and the code wraps from 63 to 0. The regulator behaves correctly at all 64 codes.
- R7: Each axis output u is clamped to the range from −MOD_LIM to +MOD_LIM, with MOD_LIM = 16000 by default.
- R8: When an axis is clamped and its error pushes further in the clamped direction, that axis's integrator holds its value. It resumes as soon as the error reverses.
- R9: The outputs come from the inverse rotation α' = cosθ·u_d − sinθ·u_q and β' = sinθ·u_d + cosθ·u_q, followed by a = kα', b = k(−α'/2 + (√3/2)β') and c = k(−α'/2 − (√3/2)β'). Their sum lies within ±4 of zero, and each magnitude is at most MOD_LIM + MOD_LIM/6.
- R10: For balanced references that rotate with θ and zero measured current, the d error is constant and the q error is zero, so the outputs follow a steadily ramping integrator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Marks the cycle that carries a new sample |
| theta | input | 6 | Grid angle phase word, 64 steps per turn |
| refA | input | DATA_W | Phase A current reference, signed |
| refB | input | DATA_W | Phase B current reference, signed |
| refC | input | DATA_W | Phase C current reference, signed |
| measA | input | DATA_W | Phase A measured current, signed |
| measB | input | DATA_W | Phase B measured current, signed |
| measC | input | DATA_W | Phase C measured current, signed |
| modA | output | DATA_W | Phase A modulation index, signed |
| modB | output | DATA_W | Phase B modulation index, signed |
| modC | output | DATA_W | Phase C modulation index, signed |
| modValid | output | 1 | One-cycle strobe when the three outputs are updated |

## Verification
The hardest state to reach is a frozen integrator. Neither integrator is visible at the ports, and a clamp is reached only after several samples of large, sustained error. The stimulus therefore drives a large constant error for eight samples at angle 0, which clamps d positive, and again at a quarter turn, which clamps q negative. It then reverses the error. How quickly the output leaves the limit shows whether the integrator held its value during the clamp. A full sweep of all 64 angle codes and a run of references that rotate with θ exercise the table folding and the rotating-frame arithmetic. In both cases a real-valued model in the bench provides the expected values.

// File: rtl/dqc_pkg.sv
package dqc_pkg;
  localparam int ANG_W  = 6;
  localparam int FRAC   = 14;
  localparam int TRIG_W = FRAC + 2;
  localparam int ACC_W  = 48;
  localparam int QTR    = 1 << (ANG_W - 2);

  typedef logic signed [ACC_W-1:0] acc_t;

  typedef struct packed {
    logic capture;
    logic xform;
    logic regulate;
    logic drive;
  } stage_strobe_t;

  // sqrt(2/3), sqrt(2/3)/2 and sqrt(2/3)*sqrt(3)/2 in Q14; 1/25 in Q16
  localparam acc_t C_K   = 48'sd13377;
  localparam acc_t C_KH  = 48'sd6689;
  localparam acc_t C_KR3 = 48'sd11585;
  localparam acc_t C_FB  = 48'sd2621;
endpackage

// File: rtl/dqc_trig_lut.sv
module dqc_trig_lut
  import dqc_pkg::*;
(
  input  logic [ANG_W-1:0]         angle,
  output logic signed [TRIG_W-1:0] sinV,
  output logic signed [TRIG_W-1:0] cosV
);
  localparam logic [ANG_W-1:0] QTR_STEP = ANG_W'(QTR);

  function automatic logic signed [TRIG_W-1:0] quarterSine(input logic [ANG_W-2:0] k);
    case (k)
      5'd0:  return 16'sd0;
      5'd1:  return 16'sd1606;
      5'd2:  return 16'sd3196;
      5'd3:  return 16'sd4756;
      5'd4:  return 16'sd6270;
      5'd5:  return 16'sd7723;
      5'd6:  return 16'sd9102;
      5'd7:  return 16'sd10394;
      5'd8:  return 16'sd11585;
      5'd9:  return 16'sd12665;
      5'd10: return 16'sd13623;
      5'd11: return 16'sd14449;
      5'd12: return 16'sd15137;
      5'd13: return 16'sd15679;
      5'd14: return 16'sd16069;
      5'd15: return 16'sd16305;
      5'd16: return 16'sd16384;
      default: return 16'sd0;
    endcase
  endfunction

  function automatic logic signed [TRIG_W-1:0] foldSine(input logic [ANG_W-1:0] a);
    logic signed [TRIG_W-1:0] mag;
    logic [ANG_W-3:0] idx;
    idx = a[ANG_W-3:0];
    if (a[ANG_W-2]) mag = quarterSine(5'(QTR) - 5'(idx));
    else            mag = quarterSine(5'(idx));
    return a[ANG_W-1] ? -mag : mag;
  endfunction

  assign sinV = foldSine(angle);
  assign cosV = foldSine(angle + QTR_STEP);
endmodule

// File: rtl/dqc_ctrl.sv
module dqc_ctrl
  import dqc_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleValid,
  output stage_strobe_t stb,
  output logic          outValid
);
  localparam int DEPTH = 4;
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (!rstN) vld <= '0;
    else       vld <= {vld[DEPTH-2:0], sampleValid};
  end

  assign stb.capture  = sampleValid;
  assign stb.xform    = vld[0];
  assign stb.regulate = vld[1];
  assign stb.drive    = vld[2];
  assign outValid     = vld[DEPTH-1];
endmodule

// File: rtl/dqc_datapath.sv
module dqc_datapath
  import dqc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int KP      = 512,
  parameter int KI      = 64,
  parameter int MOD_LIM = 16000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  stage_strobe_t            stb,
  input  logic [ANG_W-1:0]         theta,
  input  logic signed [DATA_W-1:0] refIn  [3],
  input  logic signed [DATA_W-1:0] measIn [3],
  output logic signed [DATA_W-1:0] modOut [3]
);
  localparam int   GAIN_SH = 8;
  localparam acc_t KP_A    = acc_t'(KP);
  localparam acc_t KI2_A   = acc_t'(2 * KI);
  localparam acc_t LIM_HI  = acc_t'(MOD_LIM);
  localparam acc_t LIM_LO  = -acc_t'(MOD_LIM);
  localparam acc_t FB_RND  = acc_t'(1) <<< 15;

  logic signed [TRIG_W-1:0] sinL, cosL;
  dqc_trig_lut lut_i (.angle(theta), .sinV(sinL), .cosV(cosL));

  // stage 1: per-phase error and angle lookup
  acc_t errAbcN [3];
  acc_t errAbc  [3];
  logic signed [TRIG_W-1:0] sin1, cos1, sin2, cos2, sin3, cos3;

  for (genvar p = 0; p < 3; p++) begin : g_err
    acc_t scaled;
    assign scaled     = (acc_t'(measIn[p]) * C_FB + FB_RND) >>> 16;
    assign errAbcN[p] = acc_t'(refIn[p]) - scaled;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < 3; p++) errAbc[p] <= '0;
      sin1 <= '0;
      cos1 <= '0;
    end else if (stb.capture) begin
      for (int p = 0; p < 3; p++) errAbc[p] <= errAbcN[p];
      sin1 <= sinL;
      cos1 <= cosL;
    end
  end

  // stage 2: stationary then rotating frame
  acc_t alphaE, betaE, dN, qN, errD, errQ;
  assign alphaE = (((errAbc[0] <<< 1) - errAbc[1] - errAbc[2]) * C_K) >>> 15;
  assign betaE  = ((errAbc[1] - errAbc[2]) * C_KR3) >>> FRAC;
  assign dN     = (acc_t'(cos1) * alphaE + acc_t'(sin1) * betaE) >>> FRAC;
  assign qN     = (acc_t'(cos1) * betaE - acc_t'(sin1) * alphaE) >>> FRAC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errD <= '0; errQ <= '0; sin2 <= '0; cos2 <= '0;
    end else if (stb.xform) begin
      errD <= dN; errQ <= qN; sin2 <= sin1; cos2 <= cos1;
    end
  end

  // stage 3: one PI per axis with clamp and integrator hold
  for (genvar x = 0; x < 2; x++) begin : g_pi
    acc_t axErr, pTerm, sum, integ, integNext, ctl;
    logic satHi, satLo, hold;
    assign axErr     = (x == 0) ? errD : errQ;
    assign pTerm     = (axErr * KP_A) >>> GAIN_SH;
    assign sum       = pTerm + (integ >>> GAIN_SH);
    assign satHi     = sum > LIM_HI;
    assign satLo     = sum < LIM_LO;
    assign hold      = (satHi && axErr > 0) || (satLo && axErr < 0);
    assign integNext = hold ? integ : integ + axErr * KI2_A;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        integ <= '0;
        ctl   <= '0;
      end else if (stb.regulate) begin
        integ <= integNext;
        ctl   <= satHi ? LIM_HI : (satLo ? LIM_LO : sum);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sin3 <= '0; cos3 <= '0;
    end else if (stb.regulate) begin
      sin3 <= sin2; cos3 <= cos2;
    end
  end

  // stage 4: back to stationary frame and to three phases
  acc_t uD, uQ, alphaU, betaU, outA, outB, outC;
  assign uD     = g_pi[0].ctl;
  assign uQ     = g_pi[1].ctl;
  assign alphaU = (acc_t'(cos3) * uD - acc_t'(sin3) * uQ) >>> FRAC;
  assign betaU  = (acc_t'(sin3) * uD + acc_t'(cos3) * uQ) >>> FRAC;
  assign outA   = (alphaU * C_K) >>> FRAC;
  assign outB   = (betaU * C_KR3 - alphaU * C_KH) >>> FRAC;
  assign outC   = (-(alphaU * C_KH) - betaU * C_KR3) >>> FRAC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < 3; p++) modOut[p] <= '0;
    end else if (stb.drive) begin
      modOut[0] <= DATA_W'(outA);
      modOut[1] <= DATA_W'(outB);
      modOut[2] <= DATA_W'(outC);
    end
  end
endmodule

// File: rtl/dqc_current_reg.sv
module dqc_current_reg
  import dqc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int KP      = 512,
  parameter int KI      = 64,
  parameter int MOD_LIM = 16000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic [ANG_W-1:0]         theta,
  input  logic signed [DATA_W-1:0] refA,
  input  logic signed [DATA_W-1:0] refB,
  input  logic signed [DATA_W-1:0] refC,
  input  logic signed [DATA_W-1:0] measA,
  input  logic signed [DATA_W-1:0] measB,
  input  logic signed [DATA_W-1:0] measC,
  output logic signed [DATA_W-1:0] modA,
  output logic signed [DATA_W-1:0] modB,
  output logic signed [DATA_W-1:0] modC,
  output logic                     modValid
);
  stage_strobe_t stb;
  logic signed [DATA_W-1:0] refV [3];
  logic signed [DATA_W-1:0] measV [3];
  logic signed [DATA_W-1:0] modV [3];

  assign refV[0]  = refA;  assign refV[1]  = refB;  assign refV[2]  = refC;
  assign measV[0] = measA; assign measV[1] = measB; assign measV[2] = measC;

  dqc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .stb(stb), .outValid(modValid)
  );

  dqc_datapath #(.DATA_W(DATA_W), .KP(KP), .KI(KI), .MOD_LIM(MOD_LIM)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .theta(theta),
    .refIn(refV), .measIn(measV), .modOut(modV)
  );

  assign modA = modV[0];
  assign modB = modV[1];
  assign modC = modV[2];
endmodule

// File: rtl/dqc_current_reg_chk.sv
module dqc_current_reg_chk #(
  parameter int DATA_W  = 16,
  parameter int MOD_LIM = 16000
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     sampleValid,
  input logic                     modValid,
  input logic signed [DATA_W-1:0] modA,
  input logic signed [DATA_W-1:0] modB,
  input logic signed [DATA_W-1:0] modC
);
  localparam int BOUND = MOD_LIM + MOD_LIM / 6;
  logic signed [DATA_W+1:0] phaseSum;
  assign phaseSum = (DATA_W+2)'(modA) + (DATA_W+2)'(modB) + (DATA_W+2)'(modC);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    modValid |-> $past(sampleValid, 4));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modValid |-> ($stable(modA) && $stable(modB) && $stable(modC)));

  // R9
  bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    modValid |-> (modA <= BOUND && modA >= -BOUND && modB <= BOUND &&
                  modB >= -BOUND && modC <= BOUND && modC >= -BOUND));

  // R9
  zero_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    modValid |-> (phaseSum <= 4 && phaseSum >= -4));
endmodule

bind dqc_current_reg dqc_current_reg_chk #(.DATA_W(DATA_W), .MOD_LIM(MOD_LIM)) chk_i (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .modValid(modValid),
  .modA(modA), .modB(modB), .modC(modC)
);

// File: tb/dqc_current_reg_tb_top.sv
module dqc_current_reg_tb_top;
  localparam int  KP  = 512;
  localparam int  KI  = 64;
  localparam int  LIM = 16000;
  localparam int  TOL = 40;
  localparam real PI  = 3.14159265358979;
  localparam real K23 = 0.816496580927726;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [5:0] theta = '0;
  logic signed [15:0] refA = '0, refB = '0, refC = '0;
  logic signed [15:0] measA = '0, measB = '0, measC = '0;
  logic signed [15:0] modA, modB, modC;
  logic modValid;

  int checks = 0;
  int fails = 0;
  real integD = 0.0;
  real integQ = 0.0;

  always #10 clk = ~clk;

  dqc_current_reg #(.DATA_W(16), .KP(KP), .KI(KI), .MOD_LIM(LIM)) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .theta(theta),
    .refA(refA), .refB(refB), .refC(refC),
    .measA(measA), .measB(measB), .measC(measC),
    .modA(modA), .modB(modB), .modC(modC), .modValid(modValid)
  );

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  task automatic check(input string req, input int act, input int exp, input int tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic piStep(input real e, inout real acc, output real u);
    real s;
    logic hi, lo;
    s = (KP / 256.0) * e + acc;
    hi = s > LIM;
    lo = s < -LIM;
    u = hi ? LIM : (lo ? -LIM : s);
    if (!((hi && e > 0.0) || (lo && e < 0.0))) acc = acc + (2.0 * KI / 256.0) * e;
  endtask

  task automatic modelStep(input int th, input int ra, input int rb, input int rc,
                           input int ma, input int mb, input int mc,
                           output real oa, output real ob, output real oc);
    real ea, eb, ec, al, be, ang, s, c, ed, eq, ud, uq, al2, be2, accD, accQ;
    ea = ra - ma / 25.0;
    eb = rb - mb / 25.0;
    ec = rc - mc / 25.0;
    al = K23 * (ea - eb / 2.0 - ec / 2.0);
    be = K23 * ($sqrt(3.0) / 2.0) * (eb - ec);
    ang = 2.0 * PI * th / 64.0;
    s = $sin(ang);
    c = $cos(ang);
    ed = c * al + s * be;
    eq = c * be - s * al;
    accD = integD;
    accQ = integQ;
    piStep(ed, accD, ud);
    piStep(eq, accQ, uq);
    integD = accD;
    integQ = accQ;
    al2 = c * ud - s * uq;
    be2 = s * ud + c * uq;
    oa = K23 * al2;
    ob = K23 * (-al2 / 2.0 + ($sqrt(3.0) / 2.0) * be2);
    oc = K23 * (-al2 / 2.0 - ($sqrt(3.0) / 2.0) * be2);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    integD = 0.0;
    integQ = 0.0;
  endtask

  task automatic runSample(input string req, input bit watchLat, input int th,
                           input int ra, input int rb, input int rc,
                           input int ma, input int mb, input int mc);
    real xa, xb, xc;
    int holdA;
    @(negedge clk);
    theta = 6'(th);
    refA = 16'(ra); refB = 16'(rb); refC = 16'(rc);
    measA = 16'(ma); measB = 16'(mb); measC = 16'(mc);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (watchLat) check("R2 valid early", int'(modValid), 0, 0);
    end
    @(negedge clk);
    modelStep(th, ra, rb, rc, ma, mb, mc, xa, xb, xc);
    check({req, " valid"}, int'(modValid), 1, 0);
    check({req, " phase a"}, int'(modA), rnd(xa), TOL);
    check({req, " phase b"}, int'(modB), rnd(xb), TOL);
    check({req, " phase c"}, int'(modC), rnd(xc), TOL);
    if (watchLat) begin
      holdA = int'(modA);
      @(negedge clk);
      check("R2 valid one cycle", int'(modValid), 0, 0);
      check("R2 output held", int'(modA), holdA, 0);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid in reset", int'(modValid), 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid", int'(modValid), 0, 0);
    check("R1 mod a", int'(modA), 0, 0);
    check("R1 mod b", int'(modB), 0, 0);
    check("R1 mod c", int'(modC), 0, 0);

    // R2 latency and hold, with R5 first-sample response
    runSample("R2 R5 first", 1'b1, 5, 1000, -300, -700, 0, 0, 0);

    // R3 feedback scaling: measured = 25 x reference gives zero
    doReset();
    runSample("R3 balanced", 1'b0, 9, 100, -40, -60, 2500, -1000, -1500);
    check("R3 exact a", int'(modA), 0, 0);
    check("R3 exact b", int'(modB), 0, 0);
    check("R3 exact c", int'(modC), 0, 0);

    // R4 R5 assorted patterns, integrator carried across samples
    doReset();
    runSample("R4 pat0", 1'b0, 0, 800, -200, -600, 0, 0, 0);
    runSample("R4 pat1", 1'b0, 13, -500, 900, -400, 2500, -5000, 2500);
    runSample("R4 pat2", 1'b0, 27, 0, 600, -600, -7500, 0, 7500);
    runSample("R5 pat3", 1'b0, 40, 300, 300, -600, 0, 0, 0);
    runSample("R5 pat4", 1'b0, 51, -900, 450, 450, -10000, 5000, 5000);
    runSample("R5 pat5", 1'b0, 63, 200, -700, 500, 1000, 1000, -2000);

    // R6 all angle codes
    doReset();
    for (int th = 0; th < 64; th++)
      runSample("R6 sweep", 1'b0, th, 300, -150, -150, 1000, 500, -1500);

    // R10 references rotating with the angle
    doReset();
    for (int th = 0; th < 16; th++) begin
      real ang;
      ang = 2.0 * PI * (th * 3) / 64.0;
      runSample("R10 rotating", 1'b0, th * 3,
                rnd(400.0 * $cos(ang)), rnd(400.0 * $cos(ang - 2.0 * PI / 3.0)),
                rnd(400.0 * $cos(ang + 2.0 * PI / 3.0)), 0, 0, 0);
    end

    // R7 R8 positive clamp on d, then reversal
    doReset();
    for (int n = 0; n < 8; n++) runSample("R7 clamp d", 1'b0, 0, 4000, -2000, -2000, 0, 0, 0);
    check("R7 limit a", int'(modA), 13064, TOL);
    runSample("R8 release d", 1'b0, 0, -1000, 500, 500, 0, 0, 0);
    runSample("R8 release d2", 1'b0, 0, -1000, 500, 500, 0, 0, 0);

    // R7 R8 negative clamp on q at a quarter turn
    doReset();
    for (int n = 0; n < 8; n++) runSample("R7 clamp q", 1'b0, 16, 4000, -2000, -2000, 0, 0, 0);
    check("R7 limit q a", int'(modA), 13064, TOL);
    runSample("R8 release q", 1'b0, 16, -1000, 500, 500, 0, 0, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule